// File: doc/BRIEF.md
# Conversion Request Queue with Backup

This block holds analog-to-digital conversion requests that are waiting to run, in a first-in first-out store. Each request carries a channel number, a resolution code, an external multiplexer code and a group select. The oldest stored request, or a request that was cancelled earlier and saved, is presented to a conversion arbiter. The block raises a participation request toward that arbiter while it is enabled, the external gate is open and it holds something valid.

The arbiter answers with three single-cycle pulses: start, done and cancel. Only one conversion can be in flight at a time. A start taken from the queue head removes that entry at once. The started request is kept aside so that a cancel can restore it into a one-entry backup register. While the backup holds a valid request, the backup is offered in place of the head. Software has one clear pulse. It drops the backup request if there is one, and otherwise it drops the head entry.

Requests enter over a valid/ready port. A request is taken on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` falls while the store is full. A request offered while `push_ready` is low is not held for later: it is dropped, and a sticky overflow flag is set. The arbiter-side pins are plain level and pulse signals.

Top module: `cq_req_queue`

## Requirements
- R1: When reset is released, `req_out` is 0, `offer_from_bkp` is 0, `push_ready` is 1 and `overflow` is 0. Any backup request is discarded by reset.
- R2: `req_out` equals `queue_en` AND `gate_in` AND (backup valid OR head valid), combinationally in the same cycle. While neither the backup nor the head is valid, the offer fields read zero and `offer_from_bkp` reads 0.
- R3: Accepted requests are offered in the order they were pushed. A request pushed into an empty store, with the backup empty, appears on the offer fields in the cycle after the accepting edge.
- R4: `push_ready` is 0 while DEPTH (default 8) requests are held. A push offered in that state is dropped and sets `overflow`, which stays 1 until reset.
- R5: `conv_start` takes effect only in a cycle where `req_out` is 1, no conversion is in flight and `sw_clear` is 0. A start taken from the head removes the head on that same edge.
- R6: `conv_cancel` while a head-sourced conversion is in flight places that request into the backup. From the next cycle, `offer_from_bkp` is 1 and the offer fields show the cancelled request.
- R7: While the backup is valid, the backup is offered instead of the head. Starting the backup request leaves the stored queue unchanged.
- R8: `conv_done` for a backup-sourced conversion clears the backup. `conv_done` for a head-sourced conversion leaves the backup and the queue untouched. If `conv_done` and `conv_cancel` arrive together, the cancel wins.
- R9: `sw_clear` clears the backup when the backup is valid. Otherwise it removes the head entry, and the next stored entry moves up. A `conv_start` in the same cycle is ignored.
- R10: `conv_done` and `conv_cancel` have no effect while no conversion is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | A new request is offered |
| push_ready | output | 1 | The store can take a request |
| push_chan | input | CHAN_W (5) | Channel number of the new request |
| push_res | input | RES_W (2) | Resolution code of the new request |
| push_emux | input | EMUX_W (3) | External multiplexer code of the new request |
| push_grp | input | GRP_W (1) | Group select of the new request |
| queue_en | input | 1 | Queue enable |
| gate_in | input | 1 | External gating level |
| req_out | output | 1 | Participation request to the arbiter |
| offer_chan | output | CHAN_W (5) | Channel of the offered request |
| offer_res | output | RES_W (2) | Resolution code of the offered request |
| offer_emux | output | EMUX_W (3) | Multiplexer code of the offered request |
| offer_grp | output | GRP_W (1) | Group select of the offered request |
| offer_from_bkp | output | 1 | The offered request comes from the backup |
| conv_start | input | 1 | Arbiter starts the offered request |
| conv_done | input | 1 | The in-flight conversion completed |
| conv_cancel | input | 1 | The in-flight conversion was aborted |
| sw_clear | input | 1 | Software clear pulse |
| overflow | output | 1 | Sticky flag: a push was dropped |

## Verification
`req_out` is a combinational function of the enable, the gate and the registered valid bits, so it is due in the same cycle as a change of `queue_en` or `gate_in`. Every effect of a push, start, done, cancel or clear lands on the clock edge that samples it: the new offer, backup flag, `push_ready` and `overflow` are all due one edge after the pulse. The bench drives each stimulus on a falling edge and waits for the rising edge. It samples one time unit later, while that stimulus is still applied, and compares the outputs with values worked out by hand from the requirements for the state after that edge.

// File: rtl/cq_pkg.sv
package cq_pkg;
  parameter int CHAN_W = 5;
  parameter int RES_W  = 2;
  parameter int EMUX_W = 3;
  parameter int GRP_W  = 1;

  typedef struct packed {
    logic [GRP_W-1:0]  grp;
    logic [EMUX_W-1:0] emux;
    logic [RES_W-1:0]  res;
    logic [CHAN_W-1:0] chan;
  } cq_req_t;

  localparam int REQ_W = $bits(cq_req_t);
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo
  import cq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_try,
  input  cq_req_t                  push_data,
  input  logic                     pop,
  output cq_req_t                  head_data,
  output logic                     head_v,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                     ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  cq_req_t            mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   cnt;
  logic               push_acc;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign head_v   = (cnt != '0);
  assign push_acc = push_try && !full;
  assign head_data = mem[rd_ptr];
  assign level    = cnt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_acc && (wr_ptr == PTR_W'(gi))) mem[gi] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_acc) wr_ptr <= ptr_inc(wr_ptr);
      if (pop && head_v) rd_ptr <= ptr_inc(rd_ptr);
      case ({push_acc, pop && head_v})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_try && full) ovf <= 1'b1;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !pop) |=> (cnt == $past(cnt) + 1'b1));
  // R9
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_v);
endmodule

// File: rtl/cq_track.sv
module cq_track
  import cq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_head,
  input  logic    start_bkp,
  input  cq_req_t head_data,
  input  logic    done_i,
  input  logic    cancel_i,
  input  logic    bkp_clr,
  output logic    bkp_v,
  output cq_req_t bkp_data,
  output logic    busy
);
  logic    inf_v;
  logic    inf_src_bkp;
  cq_req_t inf_data;

  assign busy = inf_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inf_v       <= 1'b0;
      inf_src_bkp <= 1'b0;
      inf_data    <= '0;
    end else if (start_head) begin
      inf_v       <= 1'b1;
      inf_src_bkp <= 1'b0;
      inf_data    <= head_data;
    end else if (start_bkp) begin
      inf_v       <= 1'b1;
      inf_src_bkp <= 1'b1;
      inf_data    <= bkp_data;
    end else if (inf_v && (done_i || cancel_i)) begin
      inf_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkp_v    <= 1'b0;
      bkp_data <= '0;
    end else if (inf_v && cancel_i) begin
      bkp_v    <= 1'b1;
      bkp_data <= inf_data;
    end else if (inf_v && done_i && inf_src_bkp) begin
      bkp_v <= 1'b0;
    end else if (bkp_clr) begin
      bkp_v <= 1'b0;
    end
  end

  // R5
  inf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_v && !done_i && !cancel_i) |=> (inf_v && $stable(inf_data)));
  // R6
  cancel_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_v && cancel_i) |=> (bkp_v && bkp_data == $past(inf_data)));
  // R8
  bkp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_v && done_i && !cancel_i && inf_src_bkp) |=> !bkp_v);
  // R10
  idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inf_v && !start_head && !start_bkp) |=> !inf_v);
endmodule

// File: rtl/cq_req_queue.sv
module cq_req_queue
  import cq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic [RES_W-1:0]  push_res,
  input  logic [EMUX_W-1:0] push_emux,
  input  logic [GRP_W-1:0]  push_grp,
  input  logic              queue_en,
  input  logic              gate_in,
  output logic              req_out,
  output logic [CHAN_W-1:0] offer_chan,
  output logic [RES_W-1:0]  offer_res,
  output logic [EMUX_W-1:0] offer_emux,
  output logic [GRP_W-1:0]  offer_grp,
  output logic              offer_from_bkp,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic              conv_cancel,
  input  logic              sw_clear,
  output logic              overflow
);
  localparam int CNT_W = $clog2(DEPTH+1);

  cq_req_t           in_req, head_data, bkp_data, offer;
  logic              head_v, full, bkp_v, busy;
  logic [CNT_W-1:0]  level;
  logic              clr_bkp, clr_head, start_ok, start_head, start_bkp, pop;

  assign in_req = '{grp: push_grp, emux: push_emux, res: push_res, chan: push_chan};

  assign clr_bkp    = sw_clear && bkp_v;
  assign clr_head   = sw_clear && !bkp_v && head_v;
  assign req_out    = queue_en && gate_in && (bkp_v || head_v);
  assign start_ok   = conv_start && req_out && !busy && !sw_clear;
  assign start_bkp  = start_ok && bkp_v;
  assign start_head = start_ok && !bkp_v;
  assign pop        = start_head || clr_head;
  assign push_ready = !full;

  cq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_try  (push_valid),
    .push_data (in_req),
    .pop       (pop),
    .head_data (head_data),
    .head_v    (head_v),
    .full      (full),
    .level     (level),
    .ovf       (overflow)
  );

  cq_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_head (start_head),
    .start_bkp  (start_bkp),
    .head_data  (head_data),
    .done_i     (conv_done),
    .cancel_i   (conv_cancel),
    .bkp_clr    (clr_bkp),
    .bkp_v      (bkp_v),
    .bkp_data   (bkp_data),
    .busy       (busy)
  );

  always_comb begin
    if (bkp_v)       offer = bkp_data;
    else if (head_v) offer = head_data;
    else             offer = '0;
  end

  assign offer_chan     = offer.chan;
  assign offer_res      = offer.res;
  assign offer_emux     = offer.emux;
  assign offer_grp      = offer.grp;
  assign offer_from_bkp = bkp_v;

  // R7
  bkp_keeps_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bkp && !push_valid) |=> $stable(level));
  // R9
  clr_bkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && bkp_v && !(busy && conv_cancel)) |=> !offer_from_bkp);
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_start && !conv_done && !conv_cancel && !push_valid && !sw_clear)
      |=> $stable(level));
  // R2
  empty_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_v && !bkp_v) |-> (offer_chan == '0 && !req_out));
endmodule

// File: tb/cq_req_queue_test.sv
module cq_req_queue_test;
  import cq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pv = 1'b0, en = 1'b0, gt = 1'b0, st = 1'b0, dn = 1'b0, cn = 1'b0, clr = 1'b0;
  logic [4:0] ch = '0;
  logic push_ready, req_out, offer_from_bkp, overflow;
  logic [CHAN_W-1:0] offer_chan;
  logic [RES_W-1:0]  offer_res;
  logic [EMUX_W-1:0] offer_emux;
  logic [GRP_W-1:0]  offer_grp;
  int runs = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cq_req_queue uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(pv), .push_ready(push_ready),
    .push_chan(ch), .push_res(ch[1:0]), .push_emux(ch[4:2]), .push_grp(ch[0]),
    .queue_en(en), .gate_in(gt), .req_out(req_out),
    .offer_chan(offer_chan), .offer_res(offer_res), .offer_emux(offer_emux),
    .offer_grp(offer_grp), .offer_from_bkp(offer_from_bkp),
    .conv_start(st), .conv_done(dn), .conv_cancel(cn), .sw_clear(clr),
    .overflow(overflow)
  );

  typedef struct packed {
    logic pv; logic [4:0] ch; logic clr, st, dn, cn, en, gt;
    logic ereq; logic [4:0] ech; logic ebkp;
  } vec_t;

  localparam vec_t VEC [22] = '{
    '{1, 3,0,0,0,0,1,1, 1, 3,0},  // R3 push into empty
    '{1, 5,0,0,0,0,1,1, 1, 3,0},  // R3
    '{1, 7,0,0,0,0,0,1, 0, 3,0},  // R2 enable low
    '{0, 0,0,1,0,0,1,1, 1, 5,0},  // R5 start pops head
    '{0, 0,0,0,0,1,1,1, 1, 3,1},  // R6 cancel to backup
    '{0, 0,0,1,0,0,1,1, 1, 3,1},  // R7 start backup
    '{0, 0,0,1,0,0,1,1, 1, 3,1},  // R5 start while busy
    '{0, 0,0,0,1,0,1,1, 1, 5,0},  // R8 done clears backup
    '{0, 0,0,1,0,0,1,1, 1, 7,0},  // R5
    '{0, 0,0,0,1,0,1,1, 1, 7,0},  // R8 head done
    '{0, 0,1,0,0,0,1,1, 0, 0,0},  // R9 clear head
    '{1, 9,0,0,0,0,1,0, 0, 9,0},  // R2 gate low
    '{0, 0,0,1,0,0,1,0, 0, 9,0},  // R5 start without req
    '{0, 0,0,1,0,0,1,1, 0, 0,0},  // R5
    '{0, 0,0,0,0,1,1,1, 1, 9,1},  // R6
    '{1,11,0,0,0,0,1,1, 1, 9,1},  // R7 backup over head
    '{0, 0,1,0,0,0,1,1, 1,11,0},  // R9 clear backup
    '{0, 0,0,0,0,1,1,1, 1,11,0},  // R10 idle cancel
    '{0, 0,0,0,1,0,1,1, 1,11,0},  // R10 idle done
    '{0, 0,1,1,0,0,1,1, 0, 0,0},  // R9 clear beats start
    '{1,12,0,1,0,0,1,1, 1,12,0},  // R5 start on empty
    '{0, 0,0,0,1,0,1,1, 1,12,0}   // R10
  };

  task automatic chk(input string tag, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic [4:0] c, input logic cl,
                       input logic s, input logic d, input logic k);
    @(negedge clk);
    pv = p; ch = c; clr = cl; st = s; dn = d; cn = k;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req_out", req_out, 0);
    chk("R1 push_ready", push_ready, 1);
    chk("R1 overflow", overflow, 0);
    chk("R1 offer_from_bkp", offer_from_bkp, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      pv = VEC[i].pv; ch = VEC[i].ch; clr = VEC[i].clr; st = VEC[i].st;
      dn = VEC[i].dn; cn = VEC[i].cn; en = VEC[i].en; gt = VEC[i].gt;
      @(posedge clk);
      #1;
      chk($sformatf("R2 vec%0d req_out", i), req_out, VEC[i].ereq);
      chk($sformatf("R3 vec%0d offer_chan", i), offer_chan, VEC[i].ech);
      chk($sformatf("R7 vec%0d offer_from_bkp", i), offer_from_bkp, VEC[i].ebkp);
    end

    // reset clears queue before the fill test
    @(negedge clk) rst_n = 1'b0;
    pv = 0; st = 0; dn = 0; cn = 0; clr = 0; en = 1; gt = 1;
    @(negedge clk) rst_n = 1'b1;

    // R4 fill to DEPTH, then one dropped push
    for (int i = 0; i < 8; i++) begin
      drive(1, 5'(20 + i), 0, 0, 0, 0);
    end
    chk("R4 push_ready full", push_ready, 0);
    chk("R4 overflow before drop", overflow, 0);
    drive(1, 5'd28, 0, 0, 0, 0);
    chk("R4 overflow set", overflow, 1);
    idle();
    for (int i = 0; i < 8; i++) begin
      logic [4:0] e;
      e = 5'(20 + i);
      chk("R3 drain chan", offer_chan, e);
      chk("R3 drain res", offer_res, e[1:0]);
      chk("R3 drain emux", offer_emux, e[4:2]);
      chk("R3 drain grp", offer_grp, e[0]);
      drive(0, 0, 1, 0, 0, 0);  // R9 clear head
    end
    chk("R4 dropped push absent", req_out, 0);
    chk("R4 overflow sticky", overflow, 1);
    chk("R4 push_ready after drain", push_ready, 1);

    // R6 fields restored into backup, then R1 reset discards backup
    drive(1, 5'd14, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R5 head taken", req_out, 0);
    drive(0, 0, 0, 0, 1, 1);  // R8 cancel wins over done
    chk("R6 backup flag", offer_from_bkp, 1);
    chk("R6 backup res", offer_res, 2);
    chk("R6 backup emux", offer_emux, 3);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 backup dropped", offer_from_bkp, 0);
    chk("R1 req after reset", req_out, 0);
    chk("R1 overflow after reset", overflow, 0);
    @(negedge clk) rst_n = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      runs++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule